// File: doc/BRIEF.md
# Serial Register Configuration Writer

This block loads a converter's control registers through a synchronous serial port, acting as the controller. The host presents a start register address, a byte count and a flat buffer of register bytes, then pulses `start`. The block cuts the buffer into communication frames. Each frame is one instruction byte followed by no more than four data bytes. It shifts every frame out most significant bit first on `sdio` under a chip select and a serial clock that it generates itself.

The instruction byte gives the direction, the number of data bytes in the frame and the first register address of the frame. The slave advances its address for each later byte. Between two frames the block raises `syncio` for one system clock so that the slave can realign its framing. The serial clock is a divided copy of the system clock. Its half period is set for each transfer, which keeps the serial rate within the slave's limit of 10 MHz. The host sees `busy` for the length of the transfer and a single-cycle `done` at the end.

Top module: `cfg_serial_writer`

## Requirements
- R1: Each frame opens with an instruction byte laid out as bit 7 = direction (0 = write, always 0 here), bits 6:5 = number of data bytes in the frame minus one, and bits 4:0 = address of the frame's first register. The register image seen by an auto-incrementing slave equals the host buffer placed at the start address, modulo 32.
- R2: A buffer of N bytes is sent as consecutive frames of four data bytes, with the remainder in the last frame. Each frame's address is the start address plus the number of bytes already sent, modulo 32.
- R3: Bits go out MSB first, instruction byte first, then data bytes in buffer order. `sdio` changes only at falling `sclk` edges and holds steady while `sclk` is high.
- R4: Each `sclk` half period lasts `half_div` system clocks, and a `half_div` of 0 acts as 1. `sclk` rests low.
- R5: `cs_n` falls one half period before the first rising `sclk` edge of a frame. It rises at the frame's final falling edge, and `sclk` stays low whenever `cs_n` is high.
- R6: `syncio` is high for exactly one system clock between two successive frames, with `cs_n` high. A transfer of F frames gives F-1 pulses.
- R7: `busy` is high from the accepted `start` until the transfer ends. `done` is a one-cycle pulse at the end, and `busy` is low while `done` is high.
- R8: A `start` pulse during a transfer is ignored. No extra frame appears and the register image is unchanged by it.
- R9: A byte count of 0 gives `done` on the clock after `start` with no frame. A count above the buffer size is clamped to the buffer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| start_addr | input | 5 | First register address |
| byte_cnt | input | CNT_W (4) | Number of buffer bytes to write |
| buf_data | input | MAX_BYTES*8 (64) | Register bytes, byte k in bits 8k+7:8k |
| half_div | input | DIV_W (8) | SCLK half period in system clocks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| sdio | output | 1 | Serial data out |
| syncio | output | 1 | Inter-frame resynchronisation pulse |

## Verification
The transfers cover byte counts of 8, 3, 5, 1, 0 and 12 (clamped), so the bench sees frames that are full, that end short and that are single, and a frame that holds one byte. Start addresses near 31 show whether the address of a later frame wraps modulo 32. Divider values of 5, 3, 2 and 0 separate a correct half-period count from an off-by-one and show that a zero setting becomes one. A second `start` in the middle of a transfer shows whether the block accepts new work only when idle.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  localparam int unsigned FRAME_MAX = 4;
  localparam int unsigned ADDR_W    = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_HIGH,
    S_LOW,
    S_TAIL,
    S_SYNC
  } cfgw_state_e;

  // Data bytes carried by the next frame, given the bytes still pending.
  function automatic logic [2:0] frame_len(input logic [7:0] pending);
    return (pending > 8'(FRAME_MAX)) ? 3'(FRAME_MAX) : pending[2:0];
  endfunction

  // Instruction byte: direction, count minus one, first address.
  function automatic logic [7:0] instr_byte(input logic rd, input logic [2:0] nbytes,
                                            input logic [ADDR_W-1:0] addr);
    logic [2:0] m1;
    m1 = nbytes - 3'd1;
    return {rd, m1[1:0], addr};
  endfunction

endpackage

// File: rtl/cfgw_tick.sv
module cfgw_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] half,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim  = (div_q == '0) ? DIV_W'(1) : div_q;
  assign tick = run && (cnt_q == lim - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) div_q <= half;
      if (!run || tick) cnt_q <= '0;
      else              cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // R4: the divider never counts past its limit while running
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < lim));

endmodule

// File: rtl/cfgw_shift.sv
module cfgw_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       shift,
  input  logic [7:0] din,
  output logic       bit_out
);
  logic [7:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {sh_q[6:0], 1'b0};
  end

  assign bit_out = sh_q[7];

  // R3: load and shift never requested together
  p_ld_sh_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));

endmodule

// File: rtl/cfgw_seq.sv
module cfgw_seq
  import cfgw_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      start_addr,
  input  logic [CNT_W-1:0]       byte_cnt,
  input  logic [MAX_BYTES*8-1:0] buf_data,
  input  logic                   tick,
  output logic                   run,
  output logic                   load_div,
  output logic                   sh_load,
  output logic                   sh_shift,
  output logic [7:0]             sh_din,
  output logic                   sclk,
  output logic                   cs_n,
  output logic                   syncio,
  output logic                   busy,
  output logic                   done
);
  cfgw_state_e            st;
  logic [MAX_BYTES*8-1:0] buf_q;
  logic [CNT_W-1:0]       total_q, idx_q;
  logic [2:0]             chunk_q;
  logic [5:0]             bit_q;
  logic [ADDR_W-1:0]      addr_q;
  logic                   sclk_q, cs_q, sync_q, busy_q, done_q;

  // Named internal events
  logic             accept, last_bit, byte_edge, frame_end;
  logic [CNT_W-1:0] len_in, pending;
  logic [2:0]       first_chunk, next_chunk;
  logic [7:0]       data_byte;

  assign len_in      = (byte_cnt > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : byte_cnt;
  assign accept      = start && (st == S_IDLE) && (len_in != '0);
  assign pending     = total_q - idx_q;
  assign first_chunk = frame_len(8'(len_in));
  assign next_chunk  = frame_len(8'(pending));
  assign last_bit    = (bit_q == {chunk_q, 3'b111});
  assign byte_edge   = (bit_q[2:0] == 3'b111);
  assign frame_end   = (st == S_HIGH) && tick && last_bit;

  always_comb begin
    data_byte = '0;
    for (int k = 0; k < MAX_BYTES; k++)
      if (idx_q == CNT_W'(k)) data_byte = buf_q[k*8 +: 8];
  end

  always_comb begin
    unique case (st)
      S_IDLE:  sh_din = instr_byte(1'b0, first_chunk, start_addr);
      S_SYNC:  sh_din = instr_byte(1'b0, chunk_q, ADDR_W'(addr_q + ADDR_W'(idx_q)));
      default: sh_din = data_byte;
    endcase
  end

  assign sh_load  = accept || (st == S_SYNC) ||
                    ((st == S_HIGH) && tick && !last_bit && byte_edge);
  assign sh_shift = (st == S_HIGH) && tick && !last_bit && !byte_edge;
  assign run      = (st == S_LEAD) || (st == S_HIGH) || (st == S_LOW) || (st == S_TAIL);
  assign load_div = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      buf_q   <= '0;
      total_q <= '0;
      idx_q   <= '0;
      chunk_q <= '0;
      bit_q   <= '0;
      addr_q  <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      sync_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start && len_in == '0) done_q <= 1'b1;
          else if (accept) begin
            buf_q   <= buf_data;
            total_q <= len_in;
            idx_q   <= '0;
            addr_q  <= start_addr;
            chunk_q <= first_chunk;
            bit_q   <= '0;
            cs_q    <= 1'b0;
            busy_q  <= 1'b1;
            st      <= S_LEAD;
          end
        end
        S_LEAD, S_LOW: if (tick) begin
          sclk_q <= 1'b1;
          st     <= S_HIGH;
        end
        S_HIGH: if (tick) begin
          sclk_q <= 1'b0;
          if (last_bit) begin
            cs_q <= 1'b1;
            st   <= S_TAIL;
          end else begin
            bit_q <= bit_q + 6'd1;
            if (byte_edge) idx_q <= idx_q + CNT_W'(1);
            st <= S_LOW;
          end
        end
        S_TAIL: if (tick) begin
          if (idx_q != total_q) begin
            sync_q  <= 1'b1;
            chunk_q <= next_chunk;
            bit_q   <= '0;
            st      <= S_SYNC;
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_SYNC: begin
          sync_q <= 1'b0;
          cs_q   <= 1'b0;
          st     <= S_LEAD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sclk   = sclk_q;
  assign cs_n   = cs_q;
  assign syncio = sync_q;
  assign busy   = busy_q;
  assign done   = done_q;

  // R6: resync pulse lasts one system clock
  p_sync_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    syncio |=> !syncio);
  // R6: resync only while deselected
  p_sync_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    syncio |-> cs_n);
  // R5: clock rests low when deselected
  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R2: a frame never carries more than four data bytes
  p_frame_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (chunk_q != 3'd0 && chunk_q <= 3'(FRAME_MAX)));
  // R7: done is a single pulse and excludes busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8: a start while busy leaves the transfer running
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !frame_end && st != S_TAIL) |=> busy);

endmodule

// File: rtl/cfg_serial_writer.sv
module cfg_serial_writer #(
  parameter int MAX_BYTES = 8,
  parameter int DIV_W     = 8,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [4:0]             start_addr,
  input  logic [CNT_W-1:0]       byte_cnt,
  input  logic [MAX_BYTES*8-1:0] buf_data,
  input  logic [DIV_W-1:0]       half_div,
  output logic                   busy,
  output logic                   done,
  output logic                   cs_n,
  output logic                   sclk,
  output logic                   sdio,
  output logic                   syncio
);
  logic       tick, run, load_div, sh_load, sh_shift;
  logic [7:0] sh_din;

  cfgw_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(load_div), .half(half_div),
    .run(run), .tick(tick)
  );

  cfgw_seq #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .buf_data(buf_data), .tick(tick), .run(run),
    .load_div(load_div), .sh_load(sh_load), .sh_shift(sh_shift), .sh_din(sh_din),
    .sclk(sclk), .cs_n(cs_n), .syncio(syncio), .busy(busy), .done(done)
  );

  cfgw_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .shift(sh_shift),
    .din(sh_din), .bit_out(sdio)
  );

  // R3: data line holds while the serial clock is high
  p_sdio_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdio));
  // R3: a data change with the clock low happens at a falling edge or before a frame
  p_sdio_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !$stable(sdio)) |-> $fell(sclk));

endmodule

// File: tb/cfg_serial_writer_test.sv
module cfg_serial_writer_test;
  localparam int MAX   = 8;
  localparam int CNT_W = $clog2(MAX + 1);
  localparam int CLK   = 10;

  logic             clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0]       start_addr = '0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic [MAX*8-1:0] buf_data = '0;
  logic [7:0]       half_div = 8'd5;
  logic             busy, done, cs_n, sclk, sdio, syncio;

  cfg_serial_writer #(.MAX_BYTES(MAX)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .buf_data(buf_data), .half_div(half_div),
    .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk), .sdio(sdio), .syncio(syncio)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, frames = 0, sync_cnt = 0, eff_div = 5;
  logic [7:0] exp_q[$];
  int         len_q[$];
  logic [7:0] slave_mem[32];
  logic [7:0] exp_mem[32];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: behavioural slave that decodes frames and scores them
  initial begin
    time t0;
    int nb;
    logic [39:0] bits;
    forever begin
      @(negedge cs_n);
      t0 = $time; nb = 0; bits = '0;
      forever begin
        @(posedge sclk or posedge cs_n);
        if (cs_n) break;
        if (nb == 0) chk(($time - t0) == eff_div * CLK, "R5", "select lead time",
                         $time - t0, eff_div * CLK);
        bits = {bits[38:0], sdio};
        nb++;
      end
      frames++;
      if (len_q.size() == 0) chk(0, "R2", "unexpected frame bits", nb, 0);
      else begin
        int L;
        L = len_q.pop_front();
        chk(nb == L * 8, "R2", "frame bit count", nb, L * 8);
        for (int k = 0; k < L; k++) begin
          logic [7:0] e, b;
          e = exp_q.pop_front();
          b = (nb == L * 8) ? bits[(nb - 1 - 8 * k) -: 8] : 8'hxx;
          chk(b === e, (k == 0) ? "R1" : "R3", "frame byte", b, e);
        end
        if (nb == L * 8 && nb >= 16) begin
          logic [7:0] ins;
          ins = bits[nb - 1 -: 8];
          for (int j = 0; j < int'(ins[6:5]) + 1 && j < L - 1; j++)
            slave_mem[5'(ins[4:0] + 5'(j))] = bits[(nb - 9 - 8 * j) -: 8];
        end
      end
    end
  end

  // R4: high phase width
  initial begin
    time th;
    forever begin
      @(posedge sclk); th = $time;
      @(negedge sclk);
      chk(($time - th) == eff_div * CLK, "R4", "sclk high width", $time - th, eff_div * CLK);
    end
  end

  always @(posedge clk) if (rst_n && syncio) sync_cnt++;

  // Driver: pushes expected frames, then runs the transfer
  task automatic run_write(input logic [4:0] a, input int n, input int seed,
                           input int dv, input bit poke);
    logic [MAX*8-1:0] d;
    int eff, sent, c, fexp, fr0, sy0, t, mism;
    for (int k = 0; k < MAX; k++) d[k*8 +: 8] = 8'(seed * 37 + k * 11 + 1);
    eff_div = (dv == 0) ? 1 : dv;
    eff  = (n > MAX) ? MAX : n;
    sent = 0; fexp = 0;
    while (sent < eff) begin
      c = (eff - sent > 4) ? 4 : eff - sent;
      len_q.push_back(c + 1);
      exp_q.push_back({1'b0, 2'(c - 1), 5'(int'(a) + sent)});
      for (int j = 0; j < c; j++) begin
        exp_q.push_back(d[(sent + j) * 8 +: 8]);
        exp_mem[5'(int'(a) + sent + j)] = d[(sent + j) * 8 +: 8];
      end
      sent += c; fexp++;
    end
    fr0 = frames; sy0 = sync_cnt;
    @(negedge clk);
    start = 1'b1; start_addr = a; byte_cnt = CNT_W'(n); buf_data = d; half_div = 8'(dv);
    @(negedge clk);
    start = 1'b0;
    if (eff > 0) chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; start_addr = 5'd3; byte_cnt = CNT_W'(2); buf_data = ~d;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R7", "done pulse seen", done, 1);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R5", "deselected idle at done", {cs_n, sclk}, 2);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7", "done lasts one clock", {done, busy}, 0);
    repeat (3) @(negedge clk);
    chk(frames - fr0 == fexp, poke ? "R8" : "R2", "frame count", frames - fr0, fexp);
    chk(sync_cnt - sy0 == ((fexp > 0) ? fexp - 1 : 0), "R6", "resync pulses",
        sync_cnt - sy0, (fexp > 0) ? fexp - 1 : 0);
    mism = 0;
    for (int r = 0; r < 32; r++) if (slave_mem[r] !== exp_mem[r]) mism++;
    chk(mism == 0, poke ? "R8" : "R1", "register image mismatches", mism, 0);
  endtask

  initial begin
    for (int r = 0; r < 32; r++) begin slave_mem[r] = '0; exp_mem[r] = '0; end
    repeat (3) @(negedge clk);
    chk({cs_n, sclk, syncio, busy, done} == 5'b10000, "R7", "reset outputs",
        {cs_n, sclk, syncio, busy, done}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    run_write(5'd0,  8, 1, 5, 1'b0);   // two full frames
    run_write(5'd30, 3, 2, 3, 1'b0);   // short single frame near wrap
    run_write(5'd29, 5, 3, 2, 1'b0);   // frame address wraps to 1
    run_write(5'd12, 1, 4, 0, 1'b0);   // zero divider acts as one
    run_write(5'd7,  0, 5, 5, 1'b0);   // R9 empty transfer
    run_write(5'd16, 12, 6, 4, 1'b0);  // R9 clamp to buffer size
    run_write(5'd8,  8, 7, 5, 1'b1);   // R8 start while busy
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    fails++;
    $display("FAIL watchdog expired R7 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule